// File: doc/BRIEF.md
# ECP Forward Channel Transmitter

This block is the forward-direction transfer engine of an extended-capability parallel port. The host writes bytes into a 16-entry queue through two write strobes. A write on the command port queues a command byte, and a write on the data port queues a data byte. The engine takes entries from the head of the queue one at a time. It places each byte on the 8-bit port bus and runs a strobe/busy handshake with the peripheral. The host-acknowledge line tells the peripheral the kind of each byte: high means data, low means command.

A command byte with bit 7 set is a channel address. A command byte with bit 7 clear is a run-length count. To send compressed data, the host queues the count on the command port and then queues the repeated byte on the data port. The engine sends both unchanged, in that order, and keeps the last channel address it sent. A mode controller enables the handshake through `fwd_en`. A programmable threshold gives a level flag on the queue occupancy. A programmable timeout stops a handshake that the peripheral leaves hanging.

Top module: `ecp_fwd_tx`

## Requirements
- R1: After reset, `strobe_n` and `host_ack` are 1, `pd_out` is 0, `fifo_level` is 0, `fifo_empty` is 1, `tmo_err` is 0 and `chan_addr` is 0.
- R2: A byte queued on the data port is driven on `pd_out` with `host_ack` = 1 while `strobe_n` is low.
- R3: Bytes leave in the order they were written, across both write ports.
- R4: A byte queued on the command port is driven with `host_ack` = 0 while `strobe_n` is low.
- R5: When the handshake of a command byte with bit 7 = 1 completes, `chan_addr` takes bits 6:0 of that byte. A command byte with bit 7 = 0 (a run-length count) and any data byte leave `chan_addr` unchanged.
- R6: While `fwd_en` is 0, no new handshake starts and the queued entries are kept.
- R7: `fifo_level` gives the number of queued entries (0 to 16). `fifo_empty` is 1 at 0 entries and `fifo_full` is 1 at 16 entries. `thresh_flag` is 1 exactly when `fifo_level` >= `thresh`.
- R8: A write while the queue holds 16 entries is dropped.
- R9: If `wr_cmd` and `wr_data` are both high in one cycle, only one entry is queued, and it is a command.
- R10: If the peripheral does not answer within `tmo_limit` cycles in one handshake phase, `tmo_err` goes to 1 and `strobe_n` returns to 1. `tmo_err` stays at 1 until `clr_err` is pulsed. A `tmo_limit` of 0 turns the timeout off.
- R11: The entry whose handshake timed out stays at the head of the queue. After `clr_err`, it is sent again.
- R12: If `fwd_en` drops during a handshake, that byte's handshake still completes, and no further byte starts.
- R13: `strobe_n` falls only while `periph_busy` is low. `pd_out` and `host_ack` are stable while `strobe_n` is low. The next byte starts only after `periph_busy` has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_en | input | 1 | Forward handshake enable from the mode controller |
| wr_cmd | input | 1 | Queue `wr_byte` as a command |
| wr_data | input | 1 | Queue `wr_byte` as data |
| wr_byte | input | 8 | Byte to queue |
| thresh | input | 5 | Occupancy threshold |
| tmo_limit | input | 16 | Timeout in cycles per phase, 0 = off |
| clr_err | input | 1 | Clears the timeout error and resumes |
| periph_busy | input | 1 | Busy line from the peripheral |
| pd_out | output | 8 | Port data bus |
| host_ack | output | 1 | 1 = data byte, 0 = command byte |
| strobe_n | output | 1 | Active-low strobe |
| fifo_level | output | 5 | Queued entry count |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| thresh_flag | output | 1 | Level at or above threshold |
| tmo_err | output | 1 | Handshake timed out |
| chan_addr | output | 7 | Last channel address sent |

## Verification
Two situations are hard to reach from the ports. The first is a handshake that stalls and then resumes: the bench's peripheral model is switched off, so the strobe goes unanswered until the timeout fires. The model is then switched back on before `clr_err`, so the retained byte is sent again and captured. The second is a mode change in the middle of a byte: the bench waits for the falling strobe edge and drops `fwd_en` on the next clock. It then checks that exactly one byte was delivered and that the rest stay queued.

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int TOW   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic          wr_cmd,
  input  logic          wr_data,
  input  logic [DW-1:0] wr_byte,
  input  logic [LW-1:0] thresh,
  input  logic [TOW-1:0] tmo_limit,
  input  logic          clr_err,
  input  logic          periph_busy,
  output logic [DW-1:0] pd_out,
  output logic          host_ack,
  output logic          strobe_n,
  output logic [LW-1:0] fifo_level,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          thresh_flag,
  output logic          tmo_err,
  output logic [DW-2:0] chan_addr
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_REL, S_ERR} state_t;

  state_t        state;
  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] level;
  logic [TOW-1:0] cnt;
  logic [DW:0]   head;
  logic          push, pop, waiting, expired;

  assign head     = mem[rp];
  assign push     = (wr_cmd | wr_data) && (level != LW'(DEPTH));
  assign pop      = (state == S_REL) && !periph_busy;
  assign waiting  = ((state == S_STRB) && !periph_busy) || ((state == S_REL) && periph_busy);
  assign expired  = waiting && (tmo_limit != '0) && (cnt == tmo_limit - 1'b1);

  assign fifo_level  = level;
  assign fifo_empty  = (level == '0);
  assign fifo_full   = (level == LW'(DEPTH));
  assign thresh_flag = (level >= thresh);
  assign tmo_err     = (state == S_ERR);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_cmd, wr_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pd_out    <= '0;
      host_ack  <= 1'b1;
      strobe_n  <= 1'b1;
      cnt       <= '0;
      chan_addr <= '0;
    end else begin
      cnt <= waiting ? cnt + 1'b1 : '0;
      case (state)
        S_IDLE: begin
          if (fwd_en && level != '0) begin
            pd_out   <= head[DW-1:0];
            host_ack <= ~head[DW];
            state    <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (!periph_busy) begin
            strobe_n <= 1'b0;
            state    <= S_STRB;
          end
        end
        S_STRB: begin
          if (periph_busy) begin
            strobe_n <= 1'b1;
            state    <= S_REL;
          end else if (expired) begin
            strobe_n <= 1'b1;
            host_ack <= 1'b1;
            state    <= S_ERR;
          end
        end
        S_REL: begin
          if (!periph_busy) begin
            host_ack <= 1'b1;
            if (head[DW] && head[DW-1]) chan_addr <= head[DW-2:0];
            state <= S_IDLE;
          end else if (expired) begin
            host_ack <= 1'b1;
            state    <= S_ERR;
          end
        end
        S_ERR: begin
          if (clr_err) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module ecp_fwd_tx_chk #(
  parameter int DW = 8,
  parameter int LW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_err,
  input logic          periph_busy,
  input logic [DW-1:0] pd_out,
  input logic          host_ack,
  input logic          strobe_n,
  input logic [LW-1:0] fifo_level,
  input logic          fifo_empty,
  input logic          tmo_err
);
  p_bus_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && $past(!strobe_n)) |-> ($stable(pd_out) && $stable(host_ack)));
  p_strobe_free_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> !$past(periph_busy));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
  p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == $past(fifo_level)) || (fifo_level == $past(fifo_level) + 1'b1)
      || (fifo_level + 1'b1 == $past(fifo_level)));
  p_entry_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !fifo_empty);
  p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> strobe_n);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !clr_err) |=> tmo_err);
endmodule

bind ecp_fwd_tx ecp_fwd_tx_chk #(.DW(DW), .LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .periph_busy(periph_busy),
  .pd_out(pd_out), .host_ack(host_ack), .strobe_n(strobe_n),
  .fifo_level(fifo_level), .fifo_empty(fifo_empty), .tmo_err(tmo_err)
);

// File: tb/ecp_fwd_tx_test.sv
`timescale 1ns/1ps
module ecp_fwd_tx_test;
  logic clk = 0, rst_n = 0, fwd_en = 0, wr_cmd = 0, wr_data = 0, clr_err = 0, busy = 0;
  logic [7:0] wr_byte = 0;
  logic [4:0] thresh = 5'd16;
  logic [15:0] tmo_limit = 16'd0;
  logic [7:0] pd_out;
  logic host_ack, strobe_n, fifo_empty, fifo_full, thresh_flag, tmo_err;
  logic [4:0] fifo_level;
  logic [6:0] chan_addr;

  int checks = 0, errors = 0;
  logic [7:0] cap_d [64];
  logic       cap_k [64];
  int ncap = 0;
  int viol = 0;
  bit periph_on = 1;

  always #2 clk = ~clk;

  ecp_fwd_tx uut (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .wr_byte(wr_byte), .thresh(thresh), .tmo_limit(tmo_limit), .clr_err(clr_err),
    .periph_busy(busy), .pd_out(pd_out), .host_ack(host_ack), .strobe_n(strobe_n),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .thresh_flag(thresh_flag), .tmo_err(tmo_err), .chan_addr(chan_addr)
  );

  always begin
    @(negedge strobe_n);
    if (busy) viol++;
    if (periph_on) begin
      if (ncap < 64) begin cap_d[ncap] = pd_out; cap_k[ncap] = host_ack; end
      ncap++;
      repeat (2) @(posedge clk); #1 busy = 1;
      @(posedge strobe_n);
      repeat (2) @(posedge clk); #1 busy = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input bit cmd, input logic [7:0] b);
    @(negedge clk); wr_cmd = cmd; wr_data = !cmd; wr_byte = b;
    @(negedge clk); wr_cmd = 0; wr_data = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fifo_empty && strobe_n && !busy) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(strobe_n == 1 && host_ack == 1, "R1 lines", {strobe_n, host_ack}, 3);
    chk(pd_out == 0 && fifo_level == 0 && fifo_empty, "R1 queue", fifo_level, 0);
    chk(!tmo_err && chan_addr == 0, "R1 status", {tmo_err, chan_addr}, 0);
  endtask

  task automatic t_data();
    int base = ncap;
    fwd_en = 1;
    push(0, 8'h11); push(0, 8'hA2); push(0, 8'h3C);
    wait_idle();
    chk(ncap == base + 3, "R2 count", ncap - base, 3);
    chk(cap_d[base] == 8'h11 && cap_d[base+1] == 8'hA2 && cap_d[base+2] == 8'h3C,
        "R3 order", cap_d[base+1], 8'hA2);
    chk(cap_k[base] && cap_k[base+1] && cap_k[base+2], "R2 host_ack high", cap_k[base], 1);
  endtask

  task automatic t_cmd();
    int base = ncap;
    push(1, 8'h85);
    wait_idle();
    chk(chan_addr == 7'h05, "R5 channel latch", chan_addr, 5);
    push(1, 8'h03); push(0, 8'h77);
    wait_idle();
    chk(ncap == base + 3, "R3 count", ncap - base, 3);
    chk(cap_k[base] == 0 && cap_d[base] == 8'h85, "R4 command tag", cap_k[base], 0);
    chk(cap_k[base+1] == 0 && cap_d[base+1] == 8'h03 && cap_k[base+2] == 1 && cap_d[base+2] == 8'h77,
        "R4 rle then data", cap_d[base+2], 8'h77);
    chk(chan_addr == 7'h05, "R5 rle keeps channel", chan_addr, 5);
  endtask

  task automatic t_hold_thresh();
    int base = ncap;
    fwd_en = 0; thresh = 5'd3;
    push(0, 8'h01); push(0, 8'h02);
    chk(!thresh_flag && fifo_level == 2, "R7 below threshold", fifo_level, 2);
    push(0, 8'h03);
    chk(thresh_flag && fifo_level == 3, "R7 at threshold", thresh_flag, 1);
    repeat (30) @(negedge clk);
    chk(ncap == base && strobe_n && fifo_level == 3, "R6 disabled hold", ncap - base, 0);
    fwd_en = 1; wait_idle();
    chk(ncap == base + 3 && cap_d[base+2] == 8'h03, "R6 resume", ncap - base, 3);
  endtask

  task automatic t_overflow();
    int base = ncap;
    fwd_en = 0;
    for (int i = 0; i < 17; i++) push(0, 8'(8'h40 + i));
    chk(fifo_level == 16 && fifo_full, "R7 full", fifo_level, 16);
    fwd_en = 1; wait_idle();
    chk(ncap == base + 16, "R8 drop on full", ncap - base, 16);
    chk(cap_d[base+15] == 8'h4F, "R8 last kept", cap_d[base+15], 8'h4F);
  endtask

  task automatic t_both();
    int base = ncap;
    fwd_en = 0;
    @(negedge clk); wr_cmd = 1; wr_data = 1; wr_byte = 8'h9A;
    @(negedge clk); wr_cmd = 0; wr_data = 0;
    chk(fifo_level == 1, "R9 single entry", fifo_level, 1);
    fwd_en = 1; wait_idle();
    chk(ncap == base + 1 && cap_k[base] == 0 && cap_d[base] == 8'h9A, "R9 command wins",
        cap_k[base], 0);
    chk(chan_addr == 7'h1A, "R5 second channel", chan_addr, 8'h1A);
  endtask

  task automatic t_timeout();
    int base = ncap;
    periph_on = 0; tmo_limit = 16'd8;
    push(0, 8'h5A);
    repeat (5) @(negedge clk);
    chk(!tmo_err && !strobe_n, "R10 not yet expired", tmo_err, 0);
    repeat (15) @(negedge clk);
    chk(tmo_err && strobe_n, "R10 timeout raised", {tmo_err, strobe_n}, 3);
    repeat (10) @(negedge clk);
    chk(tmo_err && fifo_level == 1, "R11 entry retained", fifo_level, 1);
    periph_on = 1;
    @(negedge clk); clr_err = 1; @(negedge clk); clr_err = 0;
    wait_idle();
    chk(!tmo_err && ncap == base + 1 && cap_d[base] == 8'h5A, "R11 resend", ncap - base, 1);
  endtask

  task automatic t_drop_en();
    int base = ncap;
    fwd_en = 0;
    push(0, 8'hC1); push(0, 8'hC2);
    fwd_en = 1;
    @(negedge strobe_n);
    @(negedge clk); fwd_en = 0;
    repeat (40) @(negedge clk);
    chk(ncap == base + 1 && cap_d[base] == 8'hC1, "R12 one byte finished", ncap - base, 1);
    chk(fifo_level == 1 && strobe_n, "R12 rest held", fifo_level, 1);
    fwd_en = 1; wait_idle();
    chk(ncap == base + 2 && cap_d[base+1] == 8'hC2, "R12 resume", ncap - base, 2);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_data();
    t_cmd();
    t_hold_thresh();
    t_overflow();
    t_both();
    t_timeout();
    t_drop_en();
    chk(viol == 0, "R13 strobe vs busy", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule